// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests from a parameterized number of nodes (33 by default) and picks the one the processor should service next. Each node has a control byte with a pending flag, an enable, a 4-bit interrupt level and a 2-bit group level. Software reaches the bytes through a simple 16-bit register port with a per-bit write mask, so a single bit or a whole word can be changed in one access. Several hardware request lines may share one node. Any of them sets that node's pending flag, and the lines then share the node's level and enable.

Every clock, the arbiter compares the enabled, pending nodes against a global enable and the current processor priority field, both taken from the processor status word. A node is accepted only if its level is strictly above that field. The winning node index goes out as a vector with a request strobe. Both hold steady until the processor pulses acknowledge. That pulse clears the winner's pending flag, and arbitration then resumes.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every control byte reads as 0 and `irq_req` is 0.
- R2: A read returns 0 in bits 15..8, and a write never stores bits 15..8 (writing 16'hFFFF with a full mask reads back as 16'h00FF).
- R3: A write changes only the bits whose `reg_wmask` bit is 1. The control byte layout is bit 7 pending, bit 6 enable, bits 5..2 interrupt level, and bits 1..0 group level.
- R4: No request is raised while `psw_ien` is 0, even with a pending, enabled node.
- R5: A pending, enabled node is accepted only when its interrupt level is strictly greater than `psw_ilvl`. Level 0 is never accepted.
- R6: A node whose enable bit is 0 raises no request, and its pending flag is kept.
- R7: Among accepted nodes, the winner has the highest interrupt level, then the highest group level, then the lowest node index.
- R8: `irq_req` and `irq_vec` hold steady until `irq_ack` is pulsed. The acknowledge clears the pending flag of the presented node and drops `irq_req` at the same edge.
- R9: A hardware request in the same cycle as a software write that clears the pending flag leaves the flag set.
- R10: Any of the `SHARE` request lines of a node (`src_req[node*SHARE+k]`) sets that node's pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N_NODES*SHARE | Hardware request lines, SHARE per node |
| reg_sel | input | SEL_W | Control register index (node number) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_wmask | input | 16 | Per-bit write enable |
| reg_rdata | output | 16 | Read data of the selected register |
| psw_ien | input | 1 | Global interrupt enable from the status word |
| psw_ilvl | input | 4 | Current processor priority field |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | SEL_W | Index of the presented node |
| irq_ack | input | 1 | Acknowledge pulse from the processor |

## Verification
The bench aims at the ordering rules. Four nodes are made pending with clashing levels and group levels, including a full tie that only the node index settles. A wrong comparison order or a wrong tie-break shows up as vectors in the wrong sequence.

It probes the acceptance boundary with a node whose level equals the priority field and with a level-0 node. A design that uses greater-or-equal would raise a request that should not appear.

It also drives a hardware pulse in the same cycle as a software clear. A design that lets the write win would lose the request. It pulses the second shared line of a node, which catches a design that only reads one line. Finally it holds the vector for several cycles before acknowledging, which catches a design that switches away from the presented node early.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ILVL_W = 4;
    localparam int GLVL_W = 2;
    localparam int REG_W  = 16;
    localparam int CTL_W  = 2 + ILVL_W + GLVL_W;

    typedef struct packed {
        logic              pend;
        logic              en;
        logic [ILVL_W-1:0] ilvl;
        logic [GLVL_W-1:0] glvl;
    } irq_ctl_t;
endpackage

// File: rtl/irq_node_regs.sv
module irq_node_regs
    import irq_pkg::*;
#(
    parameter int SHARE = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic [CTL_W-1:0]     wr_data,
    input  logic [CTL_W-1:0]     wr_mask,
    input  logic                 ack_hit,
    input  logic [SHARE-1:0]     hw_lines,
    output irq_ctl_t             ctl_q
);
    irq_ctl_t ctl_d;
    logic     hw_any;

    assign hw_any = |hw_lines;

    always_comb begin
        logic [CTL_W-1:0] bits;
        bits = ctl_q;
        if (wr_hit) begin
            bits = (bits & ~wr_mask) | (wr_data & wr_mask);
        end
        ctl_d = irq_ctl_t'(bits);
        if (ack_hit) begin
            ctl_d.pend = 1'b0;
        end
        if (hw_any) begin
            ctl_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R9: a hardware pulse always leaves the pending flag set
    p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_any |=> ctl_q.pend);

    // R8: acknowledge clears the flag unless something sets it again
    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !hw_any && !(wr_hit && wr_mask[CTL_W-1] && wr_data[CTL_W-1]))
        |=> !ctl_q.pend);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_NODES = 33,
    parameter int SEL_W   = $clog2(N_NODES)
) (
    input  irq_ctl_t            ctl [N_NODES],
    input  logic                ien,
    input  logic [ILVL_W-1:0]   cpu_ilvl,
    output logic                win_valid,
    output logic [SEL_W-1:0]    win_idx,
    output logic [ILVL_W-1:0]   win_ilvl
);
    localparam int KEY_W = ILVL_W + GLVL_W;

    logic [N_NODES-1:0] cand;

    generate
        for (genvar g = 0; g < N_NODES; g++) begin : g_cand
            assign cand[g] = ien && ctl[g].pend && ctl[g].en && (ctl[g].ilvl > cpu_ilvl);
        end
    endgenerate

    always_comb begin
        logic [KEY_W-1:0] best_key;
        best_key  = '0;
        win_valid = 1'b0;
        win_idx   = '0;
        win_ilvl  = '0;
        for (int i = N_NODES - 1; i >= 0; i--) begin
            if (cand[i] && (!win_valid || {ctl[i].ilvl, ctl[i].glvl} >= best_key)) begin
                win_valid = 1'b1;
                best_key  = {ctl[i].ilvl, ctl[i].glvl};
                win_idx   = SEL_W'(i);
                win_ilvl  = ctl[i].ilvl;
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_NODES = 33,
    parameter int SHARE   = 2,
    parameter int SEL_W   = $clog2(N_NODES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_NODES*SHARE-1:0] src_req,
    input  logic [SEL_W-1:0]         reg_sel,
    input  logic                     reg_wr,
    input  logic [REG_W-1:0]         reg_wdata,
    input  logic [REG_W-1:0]         reg_wmask,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic                     psw_ien,
    input  logic [ILVL_W-1:0]        psw_ilvl,
    output logic                     irq_req,
    input  logic                     irq_ack,
    output logic [SEL_W-1:0]         irq_vec
);
    typedef struct packed {
        logic             req;
        logic [SEL_W-1:0] vec;
    } out_t;

    irq_ctl_t          ctl [N_NODES];
    out_t              out_d, out_q;
    logic              win_valid;
    logic [SEL_W-1:0]  win_idx;
    logic [ILVL_W-1:0] win_ilvl;
    logic              ack_ok;
    logic              unused_upper;

    assign unused_upper = ^{reg_wdata[REG_W-1:CTL_W], reg_wmask[REG_W-1:CTL_W]};
    assign ack_ok       = irq_ack && out_q.req;

    generate
        for (genvar n = 0; n < N_NODES; n++) begin : g_node
            irq_node_regs #(.SHARE(SHARE)) u_node (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_hit   (reg_wr && (reg_sel == SEL_W'(n))),
                .wr_data  (reg_wdata[CTL_W-1:0]),
                .wr_mask  (reg_wmask[CTL_W-1:0]),
                .ack_hit  (ack_ok && (out_q.vec == SEL_W'(n))),
                .hw_lines (src_req[n*SHARE +: SHARE]),
                .ctl_q    (ctl[n])
            );
        end
    endgenerate

    irq_arbiter #(.N_NODES(N_NODES), .SEL_W(SEL_W)) u_arb (
        .ctl       (ctl),
        .ien       (psw_ien),
        .cpu_ilvl  (psw_ilvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_ilvl  (win_ilvl)
    );

    always_comb begin
        reg_rdata = '0;
        if (32'(reg_sel) < N_NODES) begin
            reg_rdata[CTL_W-1:0] = ctl[reg_sel];
        end
    end

    always_comb begin
        out_d = out_q;
        if (ack_ok) begin
            out_d.req = 1'b0;
        end else if (!out_q.req) begin
            out_d.req = win_valid;
            out_d.vec = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_req = out_q.req;
    assign irq_vec = out_q.vec;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    p_ien_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(psw_ien));

    p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(win_ilvl) > $past(psw_ilvl)));
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
    localparam int N  = 33;
    localparam int SH = 2;
    localparam int SW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*SH-1:0] src_req = '0;
    logic [SW-1:0]   reg_sel = '0;
    logic            reg_wr = 1'b0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_wmask = '0;
    logic [15:0]     reg_rdata;
    logic            psw_ien = 1'b0;
    logic [3:0]      psw_ilvl = '0;
    logic            irq_req;
    logic            irq_ack = 1'b0;
    logic [SW-1:0]   irq_vec;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_ctrl #(.N_NODES(N), .SHARE(SH)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
        .reg_rdata(reg_rdata), .psw_ien(psw_ien), .psw_ilvl(psw_ilvl),
        .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [15:0] d, input logic [15:0] m);
        @(negedge clk);
        reg_sel = SW'(sel); reg_wdata = d; reg_wmask = m; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input int sel, input int exp);
        @(negedge clk);
        reg_sel = SW'(sel);
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic expect_vec(input int v);
        exp_q.push_back(v);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        repeat (4) @(negedge clk);
        check(req, int'(irq_req), 0);
    endtask

    // monitor: pop expected vector, check hold, then acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (irq_req) begin
                int exp_v;
                int seen;
                seen = int'(irq_vec);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected request actual=0x%0h expected=none", seen);
                end else begin
                    exp_v = exp_q.pop_front();
                    check("R7 vector order", seen, exp_v);
                end
                repeat (2) begin
                    @(negedge clk);
                    check("R8 request held", int'(irq_req), 1);
                    check("R8 vector held", int'(irq_vec), seen);
                end
                irq_ack = 1'b1;
                @(negedge clk);
                irq_ack = 1'b0;
                check("R8 request dropped after ack", int'(irq_req), 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq_req after reset", int'(irq_req), 0);
        rd_check("R1 node0 reset", 0, 0);
        rd_check("R1 node32 reset", 32, 0);

        // R2 upper half discarded and read as zero
        wr(0, 16'hFFFF, 16'hFFFF);
        rd_check("R2 upper byte zero", 0, 16'h00FF);
        wr(0, 16'h0000, 16'hFFFF);
        rd_check("R2 cleared", 0, 0);

        // R3 masked write
        wr(1, 16'h00FF, 16'h0003);
        rd_check("R3 masked bits only", 1, 16'h0003);

        // R9 hardware set beats software clear in the same cycle
        wr(12, 16'h0080, 16'h0080);
        @(negedge clk);
        reg_sel = SW'(12); reg_wdata = 16'h0000; reg_wmask = 16'h0080; reg_wr = 1'b1;
        src_req[12*SH] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; src_req = '0;
        rd_check("R9 flag kept set", 12, 16'h0080);

        // R10 second shared line sets the node flag
        @(negedge clk);
        src_req[13*SH+1] = 1'b1;
        @(negedge clk);
        src_req = '0;
        rd_check("R10 shared line sets flag", 13, 16'h0080);

        // R4 global enable gates acceptance
        wr(2, 16'h00CC, 16'h00FF);
        check_idle("R4 no request while ien=0");
        expect_vec(2);
        psw_ien = 1'b1;
        drain();
        rd_check("R8 flag cleared by ack", 2, 16'h004C);

        // R5 strict level comparison, level 0 never accepted
        wr(8, 16'h00C0, 16'h00FF);
        check_idle("R5 level 0 not accepted");
        @(negedge clk); psw_ilvl = 4'd6;
        wr(5, 16'h00D8, 16'h00FF);
        check_idle("R5 equal level not accepted");
        expect_vec(5);
        psw_ilvl = 4'd5;
        drain();
        psw_ilvl = 4'd0;

        // R6 disabled node keeps its flag, then enabling by one bit (R3)
        wr(9, 16'h00A4, 16'h00FF);
        check_idle("R6 disabled node silent");
        rd_check("R6 flag kept", 9, 16'h00A4);
        expect_vec(9);
        wr(9, 16'h00FF, 16'h0040);
        drain();
        rd_check("R3 single bit write result", 9, 16'h0064);

        // R7 ordering: level, then group level, then lowest index
        psw_ien = 1'b0;
        wr(3,  16'h00D5, 16'h00FF);
        wr(10, 16'h00D6, 16'h00FF);
        wr(7,  16'h00D6, 16'h00FF);
        wr(20, 16'h00DC, 16'h00FF);
        check_idle("R4 no request while ien=0 (batch)");
        expect_vec(20); expect_vec(7); expect_vec(10); expect_vec(3);
        @(negedge clk); psw_ien = 1'b1;
        drain();
        check_idle("R7 all serviced");
        check("R7 queue empty", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule